// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one operation on a raw 8-bit NAND flash bus each time it is started. An operation is described by a 13-bit phase mask. Each mask bit turns on one bus phase. Phases always run in a fixed order, so a single engine covers reset, status poll, ID read, page read and page program. The available phases are command latches, column and row address latches, a data write, a data read, a ready/busy wait, a status byte read and an ID read. The host sets the command bytes, address registers, byte count and phase mask, then pulses `start`. The host sees `done` when the operation is complete.

Page data moves between the flash and an internal buffer of 32-bit words. The host fills and reads this buffer through a simple word port while the engine is idle. Bytes are packed big-endian inside each word. Status and ID bytes are captured into their own output registers.

The controller has these states and transitions:
- IDLE goes to PICK on `start`.
- PICK selects the highest pending phase:
  - PICK goes to LOW for a phase that moves bytes.
  - PICK goes to TWB for the ready/busy phase.
  - PICK stays in PICK when a data phase has a byte count of zero.
  - PICK goes to DONE when no phase is left.
- LOW drives the strobe low, then goes to HIGH when its timer expires.
- HIGH is the recovery time. It returns to LOW for the next byte, or to PICK after the last byte.
- TWB goes to RBW after the turnaround delay.
- RBW goes to PICK when the flash is ready, or to DONE on timeout.
- DONE goes to IDLE.

Top module: `nand_op_engine`

## Requirements
- R1: After reset the block is idle:
  - `busy` and `done` are 0.
  - `nand_we_n` and `nand_re_n` are 1.
  - `nand_ce_n` is 4'hF.
  - `nand_dq_oe` is 0.
- R2: `op_code[k]` enables the phase of code bit k+2, and enabled phases run from code bit 14 down to code bit 2. The phase of each code bit is:
  - bit 14: command A
  - bit 13: column byte 0
  - bit 12: column byte 1
  - bit 11: row byte 0
  - bit 10: row byte 1
  - bit 9: row byte 2
  - bit 8: write data
  - bit 7: command B
  - bit 6: ready/busy wait
  - bit 5: read data
  - bit 4: command C
  - bit 3: status read
  - bit 2: ID read

  A disabled phase makes no bus cycle. Examples: reset uses op_code 0x1010 and status poll uses op_code 0x101A.
- R3: Each command cycle does the following:
  - `nand_cle` is 1 and `nand_ale` is 0.
  - `nand_we_n` is low for STROBE_CYC clocks, then high for RECOV_CYC clocks.
  - `nand_dq_o` carries `cmd_a`, `cmd_b` or `cmd_c`.
- R4: Each address cycle sets `nand_ale` high and drives one byte. Column byte p is `col_addr[8p+7:8p]` and row byte p is `row_addr[8p+7:8p]`. With N address bytes the column bytes go out first.
- R5: During an operation `nand_ce_n` equals the inverse of `row_addr[27:24]`. The ready/busy wait watches the `nand_rb` inputs selected by mask `row_addr[31:28]`; all selected inputs must be high, and unselected inputs are ignored.
- R6: The write data phase sends exactly `byte_cnt` bytes. Byte i comes from buffer word i/4, in bits [31-8*(i%4) -: 8]. A count of 0 makes no bus cycle.
- R7: The read data phase pulses `nand_re_n` `byte_cnt` times. It samples `nand_dq_i` at the end of each low time and stores byte i big-endian into word i/4. Unwritten bytes of the last word keep their old contents, and no other word changes.
- R8: The ready/busy wait starts one clock after the previous phase ends. It first waits TWB_CYC clocks, then samples the selected inputs for up to RB_TIMEOUT clocks.
  - If the inputs are ready, the remaining phases continue. Ready in the last sampled clock counts as ready.
  - If the wait runs out, `rb_timeout` is set and the operation ends without any later phase.
  - `rb_timeout` is cleared by the next start.
- R9: The status phase reads one byte into `status_byte`. The ID phase reads four bytes into `id_word`, with the first byte in bits 31:24.
- R10: `busy` rises in the clock after `start` and stays high up to and including the single clock in which `done` is high. A `start` pulse while `busy` is high is ignored.
- R11: A host buffer write is taken only while `busy` is low. A write while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, taken when idle |
| op_code | input | 13 | Phase mask, bit k = code bit k+2 |
| cmd_a | input | 8 | Command byte for code bit 14 |
| cmd_b | input | 8 | Command byte for code bit 7 |
| cmd_c | input | 8 | Command byte for code bit 4 |
| col_addr | input | 16 | Column address bytes |
| row_addr | input | 32 | Row bytes [23:0], chip enable mask [27:24], ready select [31:28] |
| byte_cnt | input | CNT_W | Bytes moved by a data phase |
| host_we | input | 1 | Host buffer word write |
| host_addr | input | BUF_AW | Host buffer word address |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Buffer word at host_addr |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe |
| nand_re_n | output | 1 | Read strobe |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb | input | 4 | Ready/busy lines, high = ready |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end pulse |
| rb_timeout | output | 1 | Ready/busy wait expired |
| status_byte | output | 8 | Last status byte |
| id_word | output | 32 | Last ID bytes |

## Verification
Two events can land in the same clock of the ready/busy wait: the flash turning ready, and the timeout counter running out. The bench releases the selected ready line so that it is first seen in exactly the last sampled clock of the wait. That clock is counted from the rising edge of the preceding write strobe. The bench then repeats the release one clock later. The first run must finish with `rb_timeout` low and the second with it high. A separate run with a command phase after the wait checks that the command is dropped after a timeout.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    localparam int CODE_W   = 13;
    localparam int ID_BYTES = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_LOW,
        ST_HIGH,
        ST_TWB,
        ST_RBW,
        ST_DONE
    } seq_st_e;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WR,
        PH_RD,
        PH_RB,
        PH_STAT,
        PH_ID
    } ph_kind_e;

    // idx is code bit minus two
    function automatic ph_kind_e kind_of(input logic [3:0] idx);
        case (idx)
            4'd12, 4'd5, 4'd2:             return PH_CMD;
            4'd11, 4'd10, 4'd9, 4'd8, 4'd7: return PH_ADDR;
            4'd6:                          return PH_WR;
            4'd4:                          return PH_RB;
            4'd3:                          return PH_RD;
            4'd1:                          return PH_STAT;
            default:                       return PH_ID;
        endcase
    endfunction

endpackage

// File: rtl/nseq_tick.sv
module nseq_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nseq_buf.sv
module nseq_buf #(
    parameter int WORDS = 16,
    parameter int AW    = 4,
    parameter int BW    = AW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [31:0]   h_wdata,
    output logic [31:0]   h_rdata,
    input  logic          e_we,
    input  logic [BW-1:0] e_idx,
    input  logic [7:0]    e_wbyte,
    output logic [7:0]    e_rbyte
);
    logic [31:0] mem [WORDS];
    logic [31:0] e_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++)
                mem[w] <= '0;
        end else begin
            if (h_we)
                mem[h_addr] <= h_wdata;
            for (int l = 0; l < 4; l++)
                if (e_we && e_idx[1:0] == 2'(3 - l))
                    mem[e_idx[BW-1:2]][8*l +: 8] <= e_wbyte;
        end
    end

    assign h_rdata = mem[h_addr];
    assign e_word  = mem[e_idx[BW-1:2]];

    always_comb begin
        unique case (e_idx[1:0])
            2'd0: e_rbyte = e_word[31:24];
            2'd1: e_rbyte = e_word[23:16];
            2'd2: e_rbyte = e_word[15:8];
            default: e_rbyte = e_word[7:0];
        endcase
    end
endmodule

// File: rtl/nand_op_engine.sv
module nand_op_engine
    import nseq_pkg::*;
#(
    parameter  int BUF_WORDS  = 16,
    parameter  int STROBE_CYC = 2,
    parameter  int RECOV_CYC  = 1,
    parameter  int TWB_CYC    = 4,
    parameter  int RB_TIMEOUT = 4000,
    localparam int BUF_AW     = $clog2(BUF_WORDS),
    localparam int CNT_W      = BUF_AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [12:0]       op_code,
    input  logic [7:0]        cmd_a,
    input  logic [7:0]        cmd_b,
    input  logic [7:0]        cmd_c,
    input  logic [15:0]       col_addr,
    input  logic [31:0]       row_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              host_we,
    input  logic [BUF_AW-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic [3:0]        nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [7:0]        nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [7:0]        nand_dq_i,
    input  logic [3:0]        nand_rb,
    output logic              busy,
    output logic              done,
    output logic              rb_timeout,
    output logic [7:0]        status_byte,
    output logic [31:0]       id_word
);
    localparam int BW    = BUF_AW + 2;
    localparam int TMR_W = $clog2(RB_TIMEOUT + TWB_CYC + STROBE_CYC + RECOV_CYC + 1) + 1;

    seq_st_e            st, st_nx;
    logic [CODE_W-1:0]  pend;
    logic [3:0]         cur;
    logic [CNT_W-1:0]   bidx, cnt_r;
    logic [7:0]         cmd_a_r, cmd_b_r, cmd_c_r;
    logic [15:0]        col_r;
    logic [31:0]        row_r;
    logic               err_r;
    logic [7:0]         stat_r;
    logic [31:0]        id_r;

    logic               hi_any;
    logic [3:0]         hi_idx;
    ph_kind_e           kind, kind_hi;
    logic [CNT_W-1:0]   cur_len, hi_len;
    logic               last_byte, rdy, is_rd, drv, bus_on;
    logic               tmr_load, tmr_exp;
    logic [TMR_W-1:0]   tmr_len;
    logic [7:0]         tx_byte, buf_byte;
    logic               buf_we;

    function automatic logic [CNT_W-1:0] nbytes(input ph_kind_e k, input logic [CNT_W-1:0] c);
        case (k)
            PH_WR, PH_RD: return c;
            PH_ID:        return CNT_W'(ID_BYTES);
            PH_RB:        return '0;
            default:      return CNT_W'(1);
        endcase
    endfunction

    // highest pending phase
    always_comb begin
        hi_any = 1'b0;
        hi_idx = 4'd0;
        for (int i = 0; i < CODE_W; i++) begin
            if (pend[i]) begin
                hi_any = 1'b1;
                hi_idx = 4'(i);
            end
        end
    end

    assign kind      = kind_of(cur);
    assign kind_hi   = kind_of(hi_idx);
    assign cur_len   = nbytes(kind, cnt_r);
    assign hi_len    = nbytes(kind_hi, cnt_r);
    assign last_byte = (bidx + CNT_W'(1)) == cur_len;
    assign rdy       = (nand_rb & row_r[31:28]) == row_r[31:28];
    assign is_rd     = (kind == PH_RD) || (kind == PH_STAT) || (kind == PH_ID);
    assign drv       = (kind == PH_CMD) || (kind == PH_ADDR) || (kind == PH_WR);
    assign buf_we    = (st == ST_LOW) && tmr_exp && (kind == PH_RD);

    nseq_tick #(.W(TMR_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_exp)
    );

    nseq_buf #(.WORDS(BUF_WORDS), .AW(BUF_AW), .BW(BW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_we    (host_we && (st == ST_IDLE)),
        .h_addr  (host_addr),
        .h_wdata (host_wdata),
        .h_rdata (host_rdata),
        .e_we    (buf_we),
        .e_idx   (bidx[BW-1:0]),
        .e_wbyte (nand_dq_i),
        .e_rbyte (buf_byte)
    );

    // next state and timer loads
    always_comb begin
        st_nx    = st;
        tmr_load = 1'b0;
        tmr_len  = TMR_W'(STROBE_CYC);
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_PICK;
            ST_PICK: begin
                if (!hi_any) begin
                    st_nx = ST_DONE;
                end else if (kind_hi == PH_RB) begin
                    st_nx    = ST_TWB;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'(TWB_CYC);
                end else if (hi_len != '0) begin
                    st_nx    = ST_LOW;
                    tmr_load = 1'b1;
                end
            end
            ST_LOW: if (tmr_exp) begin
                st_nx    = ST_HIGH;
                tmr_load = 1'b1;
                tmr_len  = TMR_W'(RECOV_CYC);
            end
            ST_HIGH: if (tmr_exp) begin
                if (last_byte) begin
                    st_nx = ST_PICK;
                end else begin
                    st_nx    = ST_LOW;
                    tmr_load = 1'b1;
                end
            end
            ST_TWB: if (tmr_exp) begin
                st_nx    = ST_RBW;
                tmr_load = 1'b1;
                tmr_len  = TMR_W'(RB_TIMEOUT);
            end
            ST_RBW: begin
                if (rdy)          st_nx = ST_PICK;
                else if (tmr_exp) st_nx = ST_DONE;
            end
            ST_DONE: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // operation datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend    <= '0;
            cur     <= '0;
            bidx    <= '0;
            cnt_r   <= '0;
            cmd_a_r <= '0;
            cmd_b_r <= '0;
            cmd_c_r <= '0;
            col_r   <= '0;
            row_r   <= '0;
            err_r   <= 1'b0;
            stat_r  <= '0;
            id_r    <= '0;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    pend    <= op_code;
                    cmd_a_r <= cmd_a;
                    cmd_b_r <= cmd_b;
                    cmd_c_r <= cmd_c;
                    col_r   <= col_addr;
                    row_r   <= row_addr;
                    cnt_r   <= byte_cnt;
                    err_r   <= 1'b0;
                end
                ST_PICK: if (hi_any) begin
                    cur          <= hi_idx;
                    pend[hi_idx] <= 1'b0;
                    bidx         <= '0;
                end
                ST_LOW: if (tmr_exp) begin
                    if (kind == PH_STAT)
                        stat_r <= nand_dq_i;
                    if (kind == PH_ID) begin
                        case (bidx[1:0])
                            2'd0: id_r[31:24] <= nand_dq_i;
                            2'd1: id_r[23:16] <= nand_dq_i;
                            2'd2: id_r[15:8]  <= nand_dq_i;
                            default: id_r[7:0] <= nand_dq_i;
                        endcase
                    end
                end
                ST_HIGH: if (tmr_exp) bidx <= bidx + CNT_W'(1);
                ST_RBW: if (!rdy && tmr_exp) err_r <= 1'b1;
                default: ;
            endcase
        end
    end

    // byte placed on the bus
    always_comb begin
        tx_byte = 8'h00;
        case (kind)
            PH_CMD: begin
                if (cur == 4'd12)     tx_byte = cmd_a_r;
                else if (cur == 4'd5) tx_byte = cmd_b_r;
                else                  tx_byte = cmd_c_r;
            end
            PH_ADDR: begin
                case (cur)
                    4'd11:   tx_byte = col_r[7:0];
                    4'd10:   tx_byte = col_r[15:8];
                    4'd9:    tx_byte = row_r[7:0];
                    4'd8:    tx_byte = row_r[15:8];
                    default: tx_byte = row_r[23:16];
                endcase
            end
            PH_WR:   tx_byte = buf_byte;
            default: tx_byte = 8'h00;
        endcase
    end

    // outputs
    always_comb begin
        bus_on      = (st == ST_LOW) || (st == ST_HIGH);
        busy        = (st != ST_IDLE);
        done        = (st == ST_DONE);
        nand_ce_n   = busy ? ~row_r[27:24] : 4'hF;
        nand_cle    = bus_on && (kind == PH_CMD);
        nand_ale    = bus_on && (kind == PH_ADDR);
        nand_we_n   = !((st == ST_LOW) && drv);
        nand_re_n   = !((st == ST_LOW) && is_rd);
        nand_dq_oe  = bus_on && drv;
        nand_dq_o   = nand_dq_oe ? tx_byte : 8'h00;
        rb_timeout  = err_r;
        status_byte = stat_r;
        id_word     = id_r;
    end
endmodule

// File: rtl/nand_op_engine_chk.sv
module nand_op_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [3:0] nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe,
    input logic       busy,
    input logic       done,
    input logic       rb_timeout
);
    a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_we_n && nand_re_n && nand_ce_n == 4'hF && !nand_dq_oe));

    a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);

    a_r5_ce_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(nand_ce_n));

    a_r8_timeout_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_timeout) |-> done);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind nand_op_engine nand_op_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe),
    .busy       (busy),
    .done       (done),
    .rb_timeout (rb_timeout)
);

// File: tb/nand_op_engine_bench.sv
module nand_op_engine_bench;
    localparam int STB = 2;
    localparam int REC = 1;
    localparam int TWB = 4;
    localparam int TO  = 50;
    localparam int AW  = 4;
    localparam int CW  = 7;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          start;
    logic [12:0]   op_code;
    logic [7:0]    cmd_a, cmd_b, cmd_c;
    logic [15:0]   col_addr;
    logic [31:0]   row_addr;
    logic [CW-1:0] byte_cnt;
    logic          host_we;
    logic [AW-1:0] host_addr;
    logic [31:0]   host_wdata, host_rdata;
    logic [3:0]    nand_ce_n;
    logic          nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]    nand_dq_o;
    logic [7:0]    nand_dq_i;
    logic [3:0]    nand_rb;
    logic          busy, done, rb_timeout;
    logic [7:0]    status_byte;
    logic [31:0]   id_word;

    nand_op_engine #(
        .BUF_WORDS(16), .STROBE_CYC(STB), .RECOV_CYC(REC),
        .TWB_CYC(TWB), .RB_TIMEOUT(TO)
    ) u_nand_op_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_c(cmd_c),
        .col_addr(col_addr), .row_addr(row_addr), .byte_cnt(byte_cnt),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb(nand_rb), .busy(busy), .done(done), .rb_timeout(rb_timeout),
        .status_byte(status_byte), .id_word(id_word)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus monitors
    int we_cnt, cle_cnt, ale_cnt, re_cnt, wrun, wlast;
    logic [7:0] wlog [0:63];

    always @(posedge nand_we_n) begin
        if (rst_n === 1'b1) begin
            if (we_cnt < 64) wlog[we_cnt] = nand_dq_o;
            if (nand_cle) cle_cnt++;
            if (nand_ale) ale_cnt++;
            we_cnt++;
        end
    end

    always @(negedge nand_re_n) begin
        nand_dq_i = 8'hA0 + 8'(re_cnt);
        re_cnt++;
    end

    always @(negedge clk) begin
        if (nand_we_n === 1'b0) wrun++;
        else begin
            if (wrun > 0) wlast = wrun;
            wrun = 0;
        end
    end

    task automatic clr_mon;
        we_cnt = 0; cle_cnt = 0; ale_cnt = 0; re_cnt = 0;
    endtask

    task automatic kick(input logic [12:0] code, input logic [CW-1:0] cnt);
        clr_mon();
        @(negedge clk);
        op_code  = code;
        byte_cnt = cnt;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    task automatic wait_done;
        int g = 0;
        while (done !== 1'b1 && g < 5000) begin
            @(negedge clk);
            g++;
        end
        if (g >= 5000) chk("R10 done reached", 32'd0, 32'd1);
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    typedef struct packed {
        logic [12:0] code;
        logic [7:0]  we;
        logic [7:0]  re;
        logic [7:0]  cle;
        logic [7:0]  ale;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{13'h1010, 8'd1,  8'd0, 8'd1, 8'd0},  // reset
        '{13'h101A, 8'd1,  8'd6, 8'd1, 8'd0},  // status poll
        '{13'h1801, 8'd2,  8'd4, 8'd1, 8'd1},  // ID read
        '{13'h1FB8, 8'd7,  8'd5, 8'd2, 8'd5},  // page read
        '{13'h1FF4, 8'd13, 8'd0, 8'd3, 8'd5},  // page program
        '{13'h0000, 8'd0,  8'd0, 8'd0, 8'd0}   // empty
    };

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] w;
        rst_n = 1'b0; start = 1'b0; op_code = '0; byte_cnt = '0;
        cmd_a = 8'h11; cmd_b = 8'h22; cmd_c = 8'h33;
        col_addr = 16'hB2B1; row_addr = 32'h12C3C2C1;
        host_we = 1'b0; host_addr = '0; host_wdata = '0;
        nand_rb = 4'hF; nand_dq_i = 8'h00;
        wrun = 0; wlast = 0;
        clr_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 idle after reset
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
        chk("R1 ce_n", nand_ce_n, 4'hF);
        chk("R1 dq_oe", nand_dq_oe, 0);

        // R2 phase masks: table of operations
        for (int v = 0; v < 6; v++) begin
            kick(VECS[v].code, 7'd5);
            wait_done();
            chk("R2 write cycles", we_cnt, VECS[v].we);
            chk("R2 read cycles", re_cnt, VECS[v].re);
            chk("R2 cle cycles", cle_cnt, VECS[v].cle);
            chk("R2 ale cycles", ale_cnt, VECS[v].ale);
            chk("R8 no timeout", rb_timeout, 0);
        end

        // R3 R4 R6 program byte order
        host_wr(4'd0, 32'h01020304);
        host_wr(4'd1, 32'h05060708);
        kick(13'h1FF4, 7'd5);
        chk("R10 busy after start", busy, 1);
        wait_done();
        chk("R3 cmd_a first", wlog[0], 8'h11);
        chk("R4 col byte 0", wlog[1], 8'hB1);
        chk("R4 col byte 1", wlog[2], 8'hB2);
        chk("R4 row byte 0", wlog[3], 8'hC1);
        chk("R4 row byte 1", wlog[4], 8'hC2);
        chk("R4 row byte 2", wlog[5], 8'hC3);
        for (int i = 0; i < 5; i++)
            chk("R6 write data", wlog[6+i], 8'(i + 1));
        chk("R3 cmd_b", wlog[11], 8'h22);
        chk("R3 cmd_c", wlog[12], 8'h33);
        chk("R3 strobe width", wlast, STB);

        // R6 zero count write
        kick(13'h0040, 7'd0);
        wait_done();
        chk("R6 zero count", we_cnt, 0);

        // R5 R10 R11 wait with selected line low
        host_wr(4'd0, 32'hAABBCCDD);
        nand_rb = 4'b1110;
        kick(13'h1010, 7'd0);
        chk("R5 ce_n", nand_ce_n, 4'b1101);
        repeat (20) @(negedge clk);
        chk("R5 waits on selected line", busy, 1);
        kick(13'h1FF4, 7'd5);          // ignored start
        host_wr(4'd0, 32'h12345678);   // ignored write
        nand_rb = 4'b0001;
        wait_done();
        chk("R10 second start ignored", we_cnt, 0);
        chk("R8 ready no timeout", rb_timeout, 0);
        repeat (3) @(negedge clk);
        chk("R10 idle after done", busy, 0);
        host_rd(4'd0, w);
        chk("R11 write while busy", w, 32'hAABBCCDD);
        nand_rb = 4'hF;

        // R7 read packing and partial word
        host_wr(4'd0, 32'hDEADBEEF);
        host_wr(4'd1, 32'hCAFEF00D);
        host_wr(4'd2, 32'h55667788);
        kick(13'h0008, 7'd5);
        wait_done();
        host_rd(4'd0, w); chk("R7 word 0", w, 32'hA0A1A2A3);
        host_rd(4'd1, w); chk("R7 partial word", w, 32'hA4FEF00D);
        host_rd(4'd2, w); chk("R7 next word kept", w, 32'h55667788);

        // R9 status and ID
        kick(13'h101A, 7'd1);
        wait_done();
        chk("R9 status byte", status_byte, 8'hA1);
        kick(13'h1801, 7'd0);
        wait_done();
        chk("R9 id word", id_word, 32'hA0A1A2A3);

        // R8 timeout drops later phases
        nand_rb = 4'h0;
        kick(13'h1014, 7'd0);
        wait_done();
        chk("R8 timeout flag", rb_timeout, 1);
        chk("R8 cmd_c dropped", we_cnt, 1);

        // R8 ready in the last sampled clock
        kick(13'h1010, 7'd0);
        chk("R8 flag cleared by start", rb_timeout, 0);
        @(posedge nand_we_n);
        repeat (REC + TWB + TO) @(posedge clk);
        @(negedge clk);
        nand_rb = 4'hF;
        wait_done();
        chk("R8 ready at last clock", rb_timeout, 0);

        // R8 ready one clock too late
        nand_rb = 4'h0;
        kick(13'h1010, 7'd0);
        @(posedge nand_we_n);
        repeat (REC + TWB + TO + 1) @(posedge clk);
        @(negedge clk);
        nand_rb = 4'hF;
        wait_done();
        chk("R8 ready too late", rb_timeout, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule